// File: doc/BRIEF.md
# Two-Cycle 8x8 Multiplier with Fixed-Point Fraction Option

This block multiplies two byte-wide operands and returns a 16-bit product, split into a high byte and a low byte, together with a carry flag and a zero flag. Three operand interpretations are available: both operands unsigned, both operands two's-complement signed, or the first operand signed and the second unsigned. Each interpretation also has a fractional variant for 1.7 fixed-point data. In that variant the product is shifted one place to the left, so that the result is again a 1.15 fraction.

A caller presents the operands and a mode code and pulses `start` for one cycle. The operands are registered on that edge. The product is formed and registered on the next edge, which also raises `done` for one cycle. The result and the flags then hold their values until a later operation completes. No other flags are produced. Register-file writeback and instruction decode belong to the surrounding core.

Top module: `mul8_frac_unit`

## Requirements
- R1: Mode code bits [1:0] = 0 treat both operands as unsigned, and `product` is their 16-bit unsigned product.
- R2: Mode code bits [1:0] = 1 treat both operands as two's-complement signed, and `product` is the 16-bit two's-complement product.
- R3: Mode code bits [1:0] = 2 treat `op_a` as signed and `op_b` as unsigned, and `product` is the 16-bit two's-complement product.
- R4: Mode code bit [2] = 1 selects the fractional variant. `product` is then the 16-bit product shifted left by one with a zero inserted at bit 0, so signed 0x80 times 0x80 gives 0x8000.
- R5: `flag_c` equals bit 15 of the product before the fractional shift, in every mode.
- R6: `flag_z` is 1 exactly when the final 16-bit `product` (after any shift) is zero.
- R7: `done` is high for exactly one cycle, two cycles after the cycle in which `start` is sampled high. `product` and the flags are valid in that cycle.
- R8: Between completions, `product`, `flag_c` and `flag_z` hold their values. Changes on `op_a`, `op_b` or `mode` without `start` have no effect on them.
- R9: While `rst_n` is low, and after it is released, `product` is 0, `flag_c` is 0, `flag_z` is 0 and `done` is 0 until an operation completes.
- R10: Mode code bits [1:0] = 3 behave as unsigned times unsigned (R1). Bit [2] still selects the fractional variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request; operands and mode are sampled with it |
| mode | input | 3 | [1:0] signedness select, [2] fractional variant |
| op_a | input | W (8) | First operand (signed in modes 1 and 2) |
| op_b | input | W (8) | Second operand (signed in mode 1 only) |
| product | output | 2W (16) | Result; high byte [15:8], low byte [7:0] |
| flag_c | output | 1 | Bit 15 of the unshifted product |
| flag_z | output | 1 | Final result is zero |
| done | output | 1 | One-cycle completion strobe |

## Verification
A start sampled at one rising edge gives `done`, `product` and both flags at the second rising edge after it. Nothing changes at the first edge. The bench drives inputs on falling edges. It checks that `done` is still low half a cycle after the sampling edge, and it checks the result and flags half a cycle after the second edge. One further falling edge later it checks that `done` has fallen. For the hold requirement, the operands and mode are changed without a start, and the outputs are compared again two full cycles later, when any wrongly triggered update would already be visible.

// File: rtl/mul8_pkg.sv
package mul8_pkg;

   typedef enum logic [1:0] {
      SGN_UU  = 2'd0,
      SGN_SS  = 2'd1,
      SGN_SU  = 2'd2,
      SGN_RSV = 2'd3
   } sign_mode_e;

   // operand A is sign-extended for signed*signed and signed*unsigned
   function automatic logic ext_a_signed(input sign_mode_e m);
      return (m == SGN_SS) || (m == SGN_SU);
   endfunction

   function automatic logic ext_b_signed(input sign_mode_e m);
      return (m == SGN_SS);
   endfunction

endpackage

// File: rtl/mul8_extend.sv
module mul8_extend #(
   parameter int W = 8,
   localparam int WO = 2 * W
) (
   input  logic [W-1:0]  val,
   input  logic          sext,
   output logic [WO-1:0] ext
);
   generate
      if (W < 2) begin : g_bad_width
         $error("mul8_extend: W must be at least 2");
      end
   endgenerate

   always_comb begin
      ext = {{(WO-W){sext & val[W-1]}}, val};
   end
endmodule

// File: rtl/mul8_array.sv
module mul8_array #(
   parameter int W = 8,
   parameter int USE_SHIFT_ADD = 0,
   localparam int WP = 2 * W
) (
   input  logic [WP-1:0] x,
   input  logic [WP-1:0] y,
   output logic [WP-1:0] p
);
   // Operands arrive already extended to WP bits; the low WP bits of the
   // modular product are exact for every signedness combination.
   generate
      if (USE_SHIFT_ADD != 0 && USE_SHIFT_ADD != 1) begin : g_bad_opt
         $error("mul8_array: USE_SHIFT_ADD must be 0 or 1");
      end
      if (USE_SHIFT_ADD == 1) begin : g_shift_add
         logic [WP-1:0] pp [WP];
         for (genvar i = 0; i < WP; i++) begin : g_pp
            assign pp[i] = y[i] ? (x << i) : '0;
         end
         always_comb begin
            p = '0;
            for (int k = 0; k < WP; k++) begin
               p = p + pp[k];
            end
         end
      end else begin : g_operator
         assign p = x * y;
      end
   endgenerate
endmodule

// File: rtl/mul8_post.sv
module mul8_post #(
   parameter int W = 8,
   localparam int WP = 2 * W
) (
   input  logic [WP-1:0] raw,
   input  logic          frac,
   output logic [WP-1:0] res,
   output logic          c_out,
   output logic          z_out
);
   always_comb begin
      res   = frac ? {raw[WP-2:0], 1'b0} : raw;
      c_out = raw[WP-1];
      z_out = (res == '0);
   end
endmodule

// File: rtl/mul8_frac_unit.sv
module mul8_frac_unit #(
   parameter int W = 8,
   parameter int USE_SHIFT_ADD = 0,
   localparam int WP = 2 * W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [2:0]    mode,
   input  logic [W-1:0]  op_a,
   input  logic [W-1:0]  op_b,
   output logic [WP-1:0] product,
   output logic          flag_c,
   output logic          flag_z,
   output logic          done
);
   import mul8_pkg::*;

   generate
      if (W < 2) begin : g_bad_width
         $error("mul8_frac_unit: W must be at least 2");
      end
   endgenerate

   // stage one: captured request
   logic [W-1:0] a_q, b_q;
   sign_mode_e   sgn_q;
   logic         frac_q;
   logic         s1_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q      <= '0;
         b_q      <= '0;
         sgn_q    <= SGN_UU;
         frac_q   <= 1'b0;
         s1_valid <= 1'b0;
      end else begin
         s1_valid <= start;
         if (start) begin
            a_q    <= op_a;
            b_q    <= op_b;
            sgn_q  <= sign_mode_e'(mode[1:0]);
            frac_q <= mode[2];
         end
      end
   end

   // stage two: extend, multiply, shift, flag
   logic [WP-1:0] a_ext, b_ext, raw_p, fin_p;
   logic          c_nxt, z_nxt;

   mul8_extend #(.W(W)) u_ext_a (
      .val(a_q), .sext(ext_a_signed(sgn_q)), .ext(a_ext)
   );
   mul8_extend #(.W(W)) u_ext_b (
      .val(b_q), .sext(ext_b_signed(sgn_q)), .ext(b_ext)
   );
   mul8_array #(.W(W), .USE_SHIFT_ADD(USE_SHIFT_ADD)) u_arr (
      .x(a_ext), .y(b_ext), .p(raw_p)
   );
   mul8_post #(.W(W)) u_post (
      .raw(raw_p), .frac(frac_q), .res(fin_p), .c_out(c_nxt), .z_out(z_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         product <= '0;
         flag_c  <= 1'b0;
         flag_z  <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= s1_valid;
         if (s1_valid) begin
            product <= fin_p;
            flag_c  <= c_nxt;
            flag_z  <= z_nxt;
         end
      end
   end

   // completion strobe lands two edges after the request
   assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> ##2 done);

   // outputs only move on a completion
   assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(product) && $stable(flag_c) && $stable(flag_z)));

   // fractional results always have a zero LSB
   assert_frac_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(frac_q)) |-> (product[0] == 1'b0));

   // without the shift, carry mirrors the top product bit
   assert_carry_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !$past(frac_q)) |-> (flag_c == product[WP-1]));

   assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flag_z == (product == '0)));
endmodule

// File: tb/mul8_frac_unit_test.sv
module mul8_frac_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic [7:0]  op_a = 8'd0;
   logic [7:0]  op_b = 8'd0;
   logic [15:0] product;
   logic        flag_c, flag_z, done;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   mul8_frac_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .op_a(op_a), .op_b(op_b), .product(product),
      .flag_c(flag_c), .flag_z(flag_z), .done(done)
   );

   localparam int NV = 17;
   // {mode, op_a, op_b}
   localparam logic [18:0] VEC [NV] = '{
      {3'd0, 8'hFF, 8'hFF},   // R1
      {3'd0, 8'h00, 8'h55},   // R1 R6 zero
      {3'd0, 8'h12, 8'h34},   // R1
      {3'd1, 8'h80, 8'h80},   // R2
      {3'd1, 8'hFF, 8'h01},   // R2 negative
      {3'd1, 8'h7F, 8'h81},   // R2
      {3'd2, 8'hFF, 8'hFF},   // R3
      {3'd2, 8'h7F, 8'hFF},   // R3
      {3'd2, 8'h80, 8'h80},   // R3
      {3'd4, 8'h80, 8'h80},   // R4 uu frac
      {3'd4, 8'hFF, 8'hFF},   // R4 R5 carry from unshifted
      {3'd5, 8'hC0, 8'h40},   // R4 ss frac
      {3'd6, 8'h80, 8'h80},   // R4 su frac
      {3'd5, 8'h00, 8'h80},   // R4 R6 zero frac
      {3'd3, 8'hFF, 8'hFF},   // R10
      {3'd7, 8'hFF, 8'hFF},   // R10 frac
      {3'd3, 8'h80, 8'h02}    // R10
   };

   // expected {c, z, result}
   function automatic logic [17:0] model(input logic [2:0] m,
                                         input logic [7:0] a,
                                         input logic [7:0] b);
      int av, bv, r;
      logic [15:0] raw, res;
      av = (m[1:0] == 2'd1 || m[1:0] == 2'd2) ? int'($signed(a)) : int'(a);
      bv = (m[1:0] == 2'd1) ? int'($signed(b)) : int'(b);
      r = av * bv;
      raw = r[15:0];
      res = m[2] ? {raw[14:0], 1'b0} : raw;
      return {raw[15], (res == 16'd0), res};
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [2:0] m, input logic [7:0] a,
                         input logic [7:0] b, input string tag);
      logic [17:0] e;
      e = model(m, a, b);
      @(negedge clk);
      mode = m; op_a = a; op_b = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b0, "R7 done early", 32'(done), 32'd0);
      @(negedge clk);
      check(done == 1'b1, "R7 done due", 32'(done), 32'd1);
      check(product == e[15:0], {tag, " product"}, 32'(product), 32'(e[15:0]));
      check(flag_c == e[17], "R5 carry", 32'(flag_c), 32'(e[17]));
      check(flag_z == e[16], "R6 zero", 32'(flag_z), 32'(e[16]));
      @(negedge clk);
      check(done == 1'b0, "R7 single pulse", 32'(done), 32'd0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      // R9 reset state
      repeat (3) @(negedge clk);
      check(product == 16'd0 && !flag_c && !flag_z && !done, "R9 in reset",
            {13'd0, done, flag_z, flag_c, product}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(product == 16'd0 && !flag_c && !flag_z && !done, "R9 after reset",
            {13'd0, done, flag_z, flag_c, product}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         run_op(VEC[i][18:16], VEC[i][15:8], VEC[i][7:0], "R1 R2 R3 R4 R10 vector");
      end

      // R4 corner: signed -1.0 * -1.0 in 1.7 gives 0x8000, carry 0
      run_op(3'd5, 8'h80, 8'h80, "R4 minus-one squared");
      check(product == 16'h8000, "R4 literal", 32'(product), 32'h8000);
      check(flag_c == 1'b0, "R5 literal carry", 32'(flag_c), 32'd0);

      // R8: inputs move without start, outputs must hold
      run_op(3'd1, 8'hFF, 8'h01, "R2 setup for hold");
      @(negedge clk);
      mode = 3'd0; op_a = 8'h00; op_b = 8'h00;
      repeat (2) @(negedge clk);
      check(product == 16'hFFFF, "R8 product held", 32'(product), 32'hFFFF);
      check(flag_c == 1'b1 && flag_z == 1'b0, "R8 flags held",
            {30'd0, flag_c, flag_z}, 32'h2);
      check(done == 1'b0, "R8 no spurious done", 32'(done), 32'd0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule